// File: doc/BRIEF.md
# Bank-Interleaved Read Burst Sequencer

This block takes a stream of burst-aligned 9-bit read addresses and turns each one into DRAM commands: it opens a row (ACT), streams a four-beat read (RD), and closes a row (PRE) when a later request needs a different one. The address is split so that the bank field sits directly above the two beat bits. Stepping a sequential stream by one burst therefore moves to the next bank, and the row and the upper column bit change only after every bank has been visited once.

Accepted requests wait in a short in-order queue, and each queued request targets a different bank. Reads are issued strictly from the head of the queue. While the head burst is still on the data bus, the entries behind it use the idle command slots to precharge and activate their own banks. Every bank keeps its own tRCD/tRP timer, and a rolling window limits activates to four per tFAW cycles. The outputs are one registered command per cycle plus a per-beat data-valid strobe with a beat index.

Top module: `ilv_burst_seq`

## Requirements
- R1: An address splits into bank = bits 4..2, row = bits 8..6 and upper column bit = bit 5. A read command carries that bank and row, and a 3-bit column equal to {bit 5, 2'b00}.
- R2: `req_rdy` is low whenever bits 1..0 of `req_addr` are not zero, so a misaligned address is never accepted and produces no command.
- R3: `req_rdy` is low while an accepted, not yet read request targets the same bank as `req_addr`.
- R4: At most one command is issued per cycle. `cmd_op` is encoded ACT = 2'b01, RD = 2'b10, PRE = 2'b11, and `cmd_vld` marks the cycle in which the command is presented.
- R5: A read to a bank appears at least T_RCD cycles after that bank's activate, and carries the row that the activate opened.
- R6: An activate to a bank appears at least T_RP cycles after that bank's precharge.
- R7: No window of T_FAW consecutive cycles contains more than four activates.
- R8: A request to a closed bank is activated first. A request that hits a bank's open row is read with no activate. A request to a different row precharges the bank and then activates it.
- R9: Each read drives `dat_vld` high for exactly four consecutive cycles, starting in the cycle the RD command appears. `dat_beat` counts 0, 1, 2, 3 over those cycles.
- R10: Back-to-back reads to banks whose rows are already open give data beats with no idle cycle between bursts.
- R11: Reads are issued in the order their requests were accepted.
- R12: After reset `cmd_vld` and `dat_vld` are low and an aligned request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Read request valid |
| req_rdy | output | 1 | Request accepted on this cycle when valid is also high |
| req_addr | input | 9 | Burst-aligned linear read address |
| cmd_vld | output | 1 | A command is presented this cycle |
| cmd_op | output | 2 | Command type: ACT, RD or PRE |
| cmd_bank | output | 3 | Target bank |
| cmd_row | output | 3 | Row for ACT and RD |
| cmd_col | output | 3 | Start column for RD |
| dat_vld | output | 1 | Data beat strobe |
| dat_beat | output | 2 | Beat index inside the current burst |

## Verification
The hardest state to reach is a fully open set of banks being read back-to-back. In that state the gap-free data stream depends on each read issuing on the exact cycle the previous burst's last beat leaves the bus, and no activate may slip in. The stimulus first opens row 0 in all eight banks with a sequential stream, and that stream also trips the four-activate window. It then drains the queue and sends a second sequential pass with the upper column bit set, so that every request is a row hit and the bench can measure a single 32-beat run. A table of mixed addresses then forces row conflicts, so that precharge and activate pairs interleave with hits, and it checks read order and field decode.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_RD   = 2'b10,
    OP_PRE  = 2'b11
  } op_e;

  localparam int unsigned MAX_ACT_IN_WINDOW = 4;
endpackage

// File: rtl/ilv_bank_ctl.sv
module ilv_bank_ctl #(
  parameter int ROW_W = 3,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             idle
);
  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (act) begin
      wait_cnt <= CW'(T_RCD);
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (pre) begin
      wait_cnt <= CW'(T_RP);
      is_open  <= 1'b0;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign idle = (wait_cnt == '0);
endmodule

// File: rtl/ilv_faw_guard.sv
module ilv_faw_guard #(
  parameter int T_FAW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic ok
);
  localparam int HW = T_FAW - 1;

  logic [HW-1:0] hist;

  function automatic int unsigned ones(input logic [HW-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < HW; i++) n += int'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HW-2:0], act};
  end

  assign ok = ones(hist) < ilv_pkg::MAX_ACT_IN_WINDOW;
endmodule

// File: rtl/ilv_beat_gen.sv
module ilv_beat_gen #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_ok,
  output logic              dat_vld,
  output logic [BEAT_W-1:0] dat_beat
);
  localparam logic [BEAT_W:0] BLV = (BEAT_W + 1)'(1 << BEAT_W);

  logic [BEAT_W:0] left;
  logic [BEAT_W:0] done;

  always_ff @(posedge clk) begin
    if (!rst_n)           left <= '0;
    else if (start)       left <= BLV;
    else if (left != '0)  left <= left - 1'b1;
  end

  assign done     = BLV - left;
  assign bus_ok   = (left <= (BEAT_W + 1)'(1));
  assign dat_vld  = (left != '0);
  assign dat_beat = done[BEAT_W-1:0];
endmodule

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import ilv_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 3,
  parameter int BEAT_W = 2,
  parameter int QD     = 4,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_FAW  = 16,
  parameter int ADDR_W = ROW_W + 1 + BANK_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cmd_vld,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [BEAT_W:0]   cmd_col,
  output logic              dat_vld,
  output logic [BEAT_W-1:0] dat_beat
);
  localparam int NB = 1 << BANK_W;
  localparam int QW = $clog2(QD);

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic              chi;
  } ent_t;

  function automatic ent_t split_addr(input logic [ADDR_W-1:0] a);
    ent_t e;
    e.bank = a[BEAT_W +: BANK_W];
    e.chi  = a[BEAT_W + BANK_W];
    e.row  = a[ADDR_W-1 -: ROW_W];
    return e;
  endfunction

  ent_t             q  [QD];
  ent_t             qn [QD];
  logic [QD-1:0]    qv, qvn;
  logic [NB-1:0]    b_open, b_idle, b_act, b_pre;
  logic [ROW_W-1:0] b_row [NB];
  logic             faw_ok, bus_ok;
  logic             rd_go, act_go, pre_go;
  logic [QW-1:0]    sel;
  ent_t             req_e;
  logic             conflict, push;

  // per-bank timers and open-row state
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign b_act[b] = act_go && (q[sel].bank == BANK_W'(b));
    assign b_pre[b] = pre_go && (q[sel].bank == BANK_W'(b));
    ilv_bank_ctl #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
      .clk(clk), .rst_n(rst_n), .act(b_act[b]), .pre(b_pre[b]),
      .row_in(q[sel].row), .is_open(b_open[b]), .open_row(b_row[b]),
      .idle(b_idle[b]));
  end

  ilv_faw_guard #(.T_FAW(T_FAW)) u_faw (
    .clk(clk), .rst_n(rst_n), .act(act_go), .ok(faw_ok));

  ilv_beat_gen #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .start(rd_go), .bus_ok(bus_ok),
    .dat_vld(dat_vld), .dat_beat(dat_beat));

  // request side
  always_comb begin
    req_e    = split_addr(req_addr);
    conflict = 1'b0;
    for (int i = 0; i < QD; i++)
      if (qv[i] && q[i].bank == req_e.bank) conflict = 1'b1;
  end
  assign req_rdy = !qv[QD-1] && (req_addr[BEAT_W-1:0] == '0) && !conflict;
  assign push    = req_vld && req_rdy;

  // scheduler: head read first, then the oldest entry whose prep step is due
  always_comb begin
    logic found;
    logic [BANK_W-1:0] bk;
    rd_go  = 1'b0;
    act_go = 1'b0;
    pre_go = 1'b0;
    sel    = '0;
    found  = 1'b0;
    bk     = q[0].bank;
    if (qv[0] && b_open[bk] && b_row[bk] == q[0].row && b_idle[bk] && bus_ok) begin
      rd_go = 1'b1;
      found = 1'b1;
    end
    for (int i = 0; i < QD; i++) begin
      bk = q[i].bank;
      if (!found && qv[i] && b_idle[bk]) begin
        if (b_open[bk] && b_row[bk] != q[i].row) begin
          pre_go = 1'b1;
          found  = 1'b1;
          sel    = QW'(i);
        end else if (!b_open[bk] && faw_ok) begin
          act_go = 1'b1;
          found  = 1'b1;
          sel    = QW'(i);
        end
      end
    end
  end

  // queue update: pop head on read, append at first free slot
  always_comb begin
    logic placed;
    qn     = q;
    qvn    = qv;
    placed = 1'b0;
    if (rd_go) begin
      for (int i = 0; i < QD - 1; i++) begin
        qn[i]  = q[i+1];
        qvn[i] = qv[i+1];
      end
      qvn[QD-1] = 1'b0;
    end
    for (int i = 0; i < QD; i++) begin
      if (push && !placed && !qvn[i]) begin
        qn[i]  = req_e;
        qvn[i] = 1'b1;
        placed = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) qv <= '0;
    else        qv <= qvn;
  end

  always_ff @(posedge clk) q <= qn;

  // registered command outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd_op   <= OP_NONE;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
    end else begin
      cmd_vld  <= rd_go || act_go || pre_go;
      cmd_op   <= rd_go ? OP_RD : act_go ? OP_ACT : pre_go ? OP_PRE : OP_NONE;
      cmd_bank <= q[sel].bank;
      cmd_row  <= q[sel].row;
      cmd_col  <= rd_go ? {q[sel].chi, {BEAT_W{1'b0}}} : '0;
    end
  end
endmodule

// File: rtl/ilv_burst_seq_chk.sv
module ilv_burst_seq_chk #(
  parameter int BANK_W = 3,
  parameter int BEAT_W = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_FAW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rdy,
  input logic [BEAT_W-1:0] req_lo,
  input logic              cmd_vld,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              dat_vld,
  input logic [BEAT_W-1:0] dat_beat,
  input logic              rd_go,
  input logic              act_go,
  input logic              pre_go
);
  localparam int NB   = 1 << BANK_W;
  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CW   = $clog2(TMAX + 2);
  localparam int HW   = T_FAW - 1;
  localparam logic [BEAT_W-1:0] LAST = '1;

  logic is_act, is_rd, is_pre;
  logic [HW-1:0] ah;

  assign is_act = cmd_vld && cmd_op == 2'b01;
  assign is_rd  = cmd_vld && cmd_op == 2'b10;
  assign is_pre = cmd_vld && cmd_op == 2'b11;

  function automatic int unsigned ones(input logic [HW-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < HW; i++) n += int'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ah <= '0;
    else        ah <= {ah[HW-2:0], is_act};
  end

  for (genvar b = 0; b < NB; b++) begin : g_bk
    logic [CW-1:0] s_act, s_pre;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_act <= '0;
        s_pre <= CW'(T_RP);
      end else begin
        if (is_act && cmd_bank == BANK_W'(b))        s_act <= CW'(1);
        else if (s_act != '0 && s_act < CW'(T_RCD))  s_act <= s_act + 1'b1;
        if (is_pre && cmd_bank == BANK_W'(b))        s_pre <= CW'(1);
        else if (s_pre < CW'(T_RP))                  s_pre <= s_pre + 1'b1;
      end
    end
    AST_RD_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd && cmd_bank == BANK_W'(b) |-> s_act >= CW'(T_RCD)); // R5
    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
      is_act && cmd_bank == BANK_W'(b) |-> s_pre >= CW'(T_RP)); // R6
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, act_go, pre_go})); // R4
  AST_FAW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> ones(ah) < 4); // R7
  AST_MISALIGNED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_lo != '0 |-> !req_rdy); // R2
  AST_RD_OPENS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> dat_vld && dat_beat == '0); // R9
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dat_vld && dat_beat != LAST |=> dat_vld && dat_beat == $past(dat_beat) + 1'b1); // R9
  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    dat_vld && dat_beat == LAST |=> !dat_vld || is_rd); // R9
endmodule

bind ilv_burst_seq ilv_burst_seq_chk #(
  .BANK_W(BANK_W), .BEAT_W(BEAT_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_FAW(T_FAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rdy(req_rdy), .req_lo(req_addr[BEAT_W-1:0]),
  .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
  .dat_vld(dat_vld), .dat_beat(dat_beat),
  .rd_go(rd_go), .act_go(act_go), .pre_go(pre_go)
);

// File: tb/ilv_burst_seq_bench.sv
module ilv_burst_seq_bench;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_FAW = 16;
  localparam int NV    = 10;

  // {addr[8:0], bank, row, col}
  localparam logic [17:0] VEC [NV] = '{
    {9'h000, 3'd0, 3'd0, 3'd0},
    {9'h004, 3'd1, 3'd0, 3'd0},
    {9'h008, 3'd2, 3'd0, 3'd0},
    {9'h00C, 3'd3, 3'd0, 3'd0},
    {9'h020, 3'd0, 3'd0, 3'd4},
    {9'h040, 3'd0, 3'd1, 3'd0},
    {9'h1FC, 3'd7, 3'd7, 3'd4},
    {9'h0B8, 3'd6, 3'd2, 3'd4},
    {9'h054, 3'd5, 3'd1, 3'd0},
    {9'h044, 3'd1, 3'd1, 3'd0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_vld = 1'b0, req_rdy;
  logic [8:0] req_addr = '0;
  logic       cmd_vld, dat_vld;
  logic [1:0] cmd_op, dat_beat;
  logic [2:0] cmd_bank, cmd_row, cmd_col;

  int nchk = 0, nbad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ilv_burst_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_FAW(T_FAW)) u_ilv_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_addr(req_addr), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .dat_vld(dat_vld), .dat_beat(dat_beat));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [8:0] a);
    @(negedge clk);
    req_vld  = 1'b1;
    req_addr = a;
    #1;
    while (!req_rdy) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  // monitor state
  int  act_cyc [8], pre_cyc [8], act_row [8];
  bit  pre_seen [8], act_seen [8];
  int  faw_ring [4];
  int  n_act = 0, n_pre = 0, run = 0, max_run = 0;
  bit  prev_vld = 0;
  logic [1:0] prev_beat = '0;
  bit  tbl_on = 0;
  int  tbl_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cmd_vld && cmd_op == 2'b01) begin // ACT
        if (pre_seen[cmd_bank])
          chk(cyc - pre_cyc[cmd_bank] >= T_RP, "R6 act-after-pre", cyc - pre_cyc[cmd_bank], T_RP);
        if (n_act >= 4)
          chk(cyc - faw_ring[n_act % 4] >= T_FAW, "R7 faw", cyc - faw_ring[n_act % 4], T_FAW);
        faw_ring[n_act % 4] = cyc;
        act_cyc[cmd_bank] = cyc;
        act_row[cmd_bank] = int'(cmd_row);
        act_seen[cmd_bank] = 1;
        n_act++;
      end
      if (cmd_vld && cmd_op == 2'b11) begin // PRE
        pre_cyc[cmd_bank] = cyc;
        pre_seen[cmd_bank] = 1;
        n_pre++;
      end
      if (cmd_vld && cmd_op == 2'b10) begin // RD
        chk(act_seen[cmd_bank], "R8 rd-needs-act", 0, 1);
        chk(cyc - act_cyc[cmd_bank] >= T_RCD, "R5 rcd", cyc - act_cyc[cmd_bank], T_RCD);
        chk(act_row[cmd_bank] == int'(cmd_row), "R5 row", int'(cmd_row), act_row[cmd_bank]);
        chk(dat_vld && dat_beat == 2'd0, "R9 first beat", int'(dat_beat), 0);
        if (tbl_on && tbl_n < NV) begin
          chk(cmd_bank == VEC[tbl_n][8:6], "R1 bank / R11 order", int'(cmd_bank), int'(VEC[tbl_n][8:6]));
          chk(cmd_row  == VEC[tbl_n][5:3], "R1 row", int'(cmd_row), int'(VEC[tbl_n][5:3]));
          chk(cmd_col  == VEC[tbl_n][2:0], "R1 col", int'(cmd_col), int'(VEC[tbl_n][2:0]));
          tbl_n++;
        end
      end else if (prev_vld && prev_beat != 2'd3) begin
        chk(dat_vld && dat_beat == prev_beat + 2'd1, "R9 beat step", int'(dat_beat), int'(prev_beat) + 1);
      end else if (prev_vld) begin
        chk(!dat_vld, "R9 burst length", int'(dat_vld), 0);
      end
      if (dat_vld) run++;
      else begin
        if (run > max_run) max_run = run;
        run = 0;
      end
      prev_vld  = dat_vld;
      prev_beat = dat_beat;
    end
  end

  initial begin
    int a0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cmd_vld, "R12 cmd idle", int'(cmd_vld), 0);
    chk(!dat_vld, "R12 data idle", int'(dat_vld), 0);
    chk(req_rdy, "R12 ready", int'(req_rdy), 1);

    // misaligned addresses are refused and issue nothing
    @(negedge clk);
    req_vld = 1'b1; req_addr = 9'h002; #1;
    chk(!req_rdy, "R2 misaligned 0x002", int'(req_rdy), 0);
    @(negedge clk);
    req_addr = 9'h003; #1;
    chk(!req_rdy, "R2 misaligned 0x003", int'(req_rdy), 0);
    @(negedge clk);
    req_vld = 1'b0;
    chk(!cmd_vld, "R2 no command", int'(cmd_vld), 0);
    repeat (3) @(negedge clk);
    chk(!cmd_vld && n_act == 0, "R2 no command later", n_act, 0);

    // same-bank conflict blocks ready
    push(9'h000);
    req_vld = 1'b1; req_addr = 9'h040; #1;
    chk(!req_rdy, "R3 same-bank blocked", int'(req_rdy), 0);
    req_vld = 1'b0;
    repeat (20) @(negedge clk);

    // phase 1: open row 0 in every bank, trips the activate window
    for (int i = 1; i < 8; i++) push(9'(i * 4));
    repeat (60) @(negedge clk);
    chk(n_act == 8, "R8 one act per closed bank", n_act, 8);

    // phase 2: all row hits, must stream without a gap
    a0 = n_act;
    max_run = 0;
    for (int i = 0; i < 8; i++) push(9'h020 + 9'(i * 4));
    repeat (40) @(negedge clk);
    chk(n_act == a0, "R8 hits skip act", n_act - a0, 0);
    chk(max_run == 32, "R10 gap-free run", max_run, 32);

    // phase 3: table of mixed hits and row conflicts
    a0 = n_act; p0 = n_pre;
    tbl_on = 1;
    for (int i = 0; i < NV; i++) push(VEC[i][17:9]);
    repeat (80) @(negedge clk);
    chk(tbl_n == NV, "R11 all reads issued", tbl_n, NV);
    chk(n_pre - p0 == 5, "R8 conflict precharges", n_pre - p0, 5);
    chk(n_act - a0 == 5, "R8 conflict activates", n_act - a0, 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule